// File: doc/BRIEF.md
# Interrupt Request Mask and Classify Front End

This block is the first stage of an interrupt controller. It takes a vector of hardware request lines, ORs a software-forced pattern into it, gates the result with an enable mask, and splits each enabled request into one of two classes. The fast class is collapsed into a single fast-interrupt output. The normal class is passed on as a per-source status vector for a later stage that picks vectors and priorities.

All configuration lives behind a simple word-wide register port. Each access is one cycle long and carries an address, a write flag, write data and a privilege qualifier. The enable mask and the software-force mask each have a write-one-to-set offset and a separate write-one-to-clear offset, so software never needs a read-modify-write. A protection bit can lock the whole register set against unprivileged accesses.

Read data and the access-error flag are registered. Both appear in the cycle after the access. The status vectors and the fast output follow the request inputs and the register state with no delay.

Top module: `irq_mask_classify`

## Requirements
- R1: The merged request vector is the bitwise OR of `src_req` and the software-force register. It reads back at offset 0x08, whatever the enable and class settings are.
- R2: A write to offset 0x10 sets every enable bit whose data bit is 1 and leaves the other bits alone. A write to offset 0x14 clears every enable bit whose data bit is 1. The enable mask reads back at 0x10.
- R3: A write to offset 0x18 sets every software-force bit whose data bit is 1. A write to offset 0x1C clears every software-force bit whose data bit is 1. Zero data bits have no effect at either offset. The force mask reads back at 0x18.
- R4: The class register at offset 0x0C is written and read as a whole word. A bit value of 1 puts that source in the fast class and 0 puts it in the normal class.
- R5: Fast status is merged AND enable AND class. It reads at 0x04. Normal status is merged AND enable AND NOT class. It reads at 0x00 and drives `norm_status`. `fast_irq` is the OR of all fast status bits. All of these follow the inputs in the same cycle.
- R6: Bit 0 at offset 0x20 is the protection bit. While it is 1, an access with `acc_priv` low has these effects: a read returns zero, a write changes nothing (the protection bit included), and `acc_err` is 1 for exactly the following cycle. While it is 0, unprivileged accesses behave like privileged ones, and `acc_err` stays 0.
- R7: `acc_rdata` holds the read value in the cycle after a read access and is zero in every other cycle. Reads of 0x14, 0x1C and of offsets with no register return zero. Writes to 0x00, 0x04, 0x08 and to offsets with no register change nothing.
- R8: After reset, every register is 0, `fast_irq` is 0 and `norm_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Hardware request lines, level sensitive |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | Access comes from a privileged master |
| acc_addr | input | ADDR_W | Byte offset of the word accessed |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, one cycle after a read |
| acc_err | output | 1 | One-cycle pulse after an access refused by protection |
| fast_irq | output | 1 | OR of all fast-class status bits |
| norm_status | output | NUM_SRC | Normal-class status vector for the vector stage |

## Verification
If an enable, class or force bit is stored wrong, the error shows up at once on `norm_status` or `fast_irq` for any source whose request is active. It also shows up in the next read of the status or raw offsets. The bench therefore drives one-hot and pseudo-random request patterns over many mask settings and compares the port vectors in the same cycle. A protection leak or a write that corrupts state appears at the first privileged readback that follows. A missing error pulse appears in the very next cycle.

// File: rtl/ism_pkg.sv
package ism_pkg;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_NSTAT,
        RID_FSTAT,
        RID_RAW,
        RID_CLASS,
        RID_ENSET,
        RID_ENCLR,
        RID_SWSET,
        RID_SWCLR,
        RID_PROT
    } reg_id_e;

    localparam logic [7:0] OFS_NSTAT = 8'h00;
    localparam logic [7:0] OFS_FSTAT = 8'h04;
    localparam logic [7:0] OFS_RAW   = 8'h08;
    localparam logic [7:0] OFS_CLASS = 8'h0C;
    localparam logic [7:0] OFS_ENSET = 8'h10;
    localparam logic [7:0] OFS_ENCLR = 8'h14;
    localparam logic [7:0] OFS_SWSET = 8'h18;
    localparam logic [7:0] OFS_SWCLR = 8'h1C;
    localparam logic [7:0] OFS_PROT  = 8'h20;

endpackage

// File: rtl/ism_decode.sv
module ism_decode
    import ism_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_priv,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              prot,
    output reg_id_e           reg_id,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              blocked
);

    localparam int unsigned EXT_W = (ADDR_W > 8) ? ADDR_W : 8;

    logic [EXT_W-1:0] addr_x;

    always_comb begin
        addr_x = EXT_W'(acc_addr);
        if      (addr_x == EXT_W'(OFS_NSTAT)) reg_id = RID_NSTAT;
        else if (addr_x == EXT_W'(OFS_FSTAT)) reg_id = RID_FSTAT;
        else if (addr_x == EXT_W'(OFS_RAW))   reg_id = RID_RAW;
        else if (addr_x == EXT_W'(OFS_CLASS)) reg_id = RID_CLASS;
        else if (addr_x == EXT_W'(OFS_ENSET)) reg_id = RID_ENSET;
        else if (addr_x == EXT_W'(OFS_ENCLR)) reg_id = RID_ENCLR;
        else if (addr_x == EXT_W'(OFS_SWSET)) reg_id = RID_SWSET;
        else if (addr_x == EXT_W'(OFS_SWCLR)) reg_id = RID_SWCLR;
        else if (addr_x == EXT_W'(OFS_PROT))  reg_id = RID_PROT;
        else                                  reg_id = RID_NONE;
    end

    always_comb begin
        blocked = acc_en && prot && !acc_priv;
        wr_ok   = acc_en && acc_wr && !blocked;
        rd_ok   = acc_en && !acc_wr && !blocked;
    end

    // R6: a refused access never turns into a read or a write
    always_comb begin
        a_r6_refused_is_inert: assert (!(blocked && (wr_ok || rd_ok)));
    end

endmodule

// File: rtl/ism_classify.sv
module ism_classify #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] soft_force,
    input  logic [NUM_SRC-1:0] enable,
    input  logic [NUM_SRC-1:0] class_fast,
    output logic [NUM_SRC-1:0] raw_vec,
    output logic [NUM_SRC-1:0] fast_vec,
    output logic [NUM_SRC-1:0] norm_vec,
    output logic               fast_any
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic live;
        assign raw_vec[i]  = src_req[i] | soft_force[i];
        assign live        = raw_vec[i] & enable[i];
        assign fast_vec[i] = live & class_fast[i];
        assign norm_vec[i] = live & ~class_fast[i];
    end

    assign fast_any = |fast_vec;

    // R5: a source never appears in both classes, and a disabled source in neither
    always_comb begin
        a_r5_class_exclusive: assert ((fast_vec & norm_vec) == '0);
        a_r5_disabled_silent: assert (((fast_vec | norm_vec) & ~enable) == '0);
    end

endmodule

// File: rtl/ism_regs.sv
module ism_regs
    import ism_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  reg_id_e            reg_id,
    input  logic               wr_ok,
    input  logic               rd_ok,
    input  logic               blocked,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] raw_vec,
    input  logic [NUM_SRC-1:0] fast_vec,
    input  logic [NUM_SRC-1:0] norm_vec,
    output logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] class_fast,
    output logic [NUM_SRC-1:0] soft_force,
    output logic               prot,
    output logic [DATA_W-1:0]  rdata,
    output logic               err
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] cls;
        logic [NUM_SRC-1:0] sw;
        logic               prot;
        logic [DATA_W-1:0]  rdata;
        logic               err;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_SRC-1:0] wd;

    assign wd = wdata[NUM_SRC-1:0];

    always_comb begin
        st_d       = st_q;
        st_d.err   = blocked;
        st_d.rdata = '0;
        if (wr_ok) begin
            case (reg_id)
                RID_ENSET: st_d.en   = st_q.en | wd;
                RID_ENCLR: st_d.en   = st_q.en & ~wd;
                RID_CLASS: st_d.cls  = wd;
                RID_SWSET: st_d.sw   = st_q.sw | wd;
                RID_SWCLR: st_d.sw   = st_q.sw & ~wd;
                RID_PROT:  st_d.prot = wdata[0];
                default:   st_d.prot = st_q.prot;
            endcase
        end
        if (rd_ok) begin
            case (reg_id)
                RID_NSTAT: st_d.rdata = DATA_W'(norm_vec);
                RID_FSTAT: st_d.rdata = DATA_W'(fast_vec);
                RID_RAW:   st_d.rdata = DATA_W'(raw_vec);
                RID_CLASS: st_d.rdata = DATA_W'(st_q.cls);
                RID_ENSET: st_d.rdata = DATA_W'(st_q.en);
                RID_SWSET: st_d.rdata = DATA_W'(st_q.sw);
                RID_PROT:  st_d.rdata = DATA_W'(st_q.prot);
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable     = st_q.en;
    assign class_fast = st_q.cls;
    assign soft_force = st_q.sw;
    assign prot       = st_q.prot;
    assign rdata      = st_q.rdata;
    assign err        = st_q.err;

    a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && reg_id == RID_ENSET) |=> ((enable & $past(wd)) == $past(wd)));
    a_r2_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && reg_id == RID_ENCLR) |=> ((enable & $past(wd)) == '0));
    a_r3_force_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && reg_id == RID_SWSET) |=> ((soft_force & $past(wd)) == $past(wd)));
    a_r3_force_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && reg_id == RID_SWCLR) |=> ((soft_force & $past(wd)) == '0));
    a_r6_blocked_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> ($stable(enable) && $stable(class_fast) && $stable(soft_force) && $stable(prot)));
    a_r6_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> (err && rdata == '0));
    a_r7_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> (rdata == '0));

endmodule

// File: rtl/irq_mask_classify.sv
module irq_mask_classify
    import ism_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               acc_en,
    input  logic               acc_wr,
    input  logic               acc_priv,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  acc_rdata,
    output logic               acc_err,
    output logic               fast_irq,
    output logic [NUM_SRC-1:0] norm_status
);

    reg_id_e            reg_id;
    logic               wr_ok, rd_ok, blocked, prot;
    logic [NUM_SRC-1:0] enable, class_fast, soft_force;
    logic [NUM_SRC-1:0] raw_vec, fast_vec, norm_vec;

    ism_decode #(.ADDR_W(ADDR_W)) u_decode (
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_priv (acc_priv),
        .acc_addr (acc_addr),
        .prot     (prot),
        .reg_id   (reg_id),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok),
        .blocked  (blocked)
    );

    ism_classify #(.NUM_SRC(NUM_SRC)) u_classify (
        .src_req    (src_req),
        .soft_force (soft_force),
        .enable     (enable),
        .class_fast (class_fast),
        .raw_vec    (raw_vec),
        .fast_vec   (fast_vec),
        .norm_vec   (norm_vec),
        .fast_any   (fast_irq)
    );

    ism_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_id     (reg_id),
        .wr_ok      (wr_ok),
        .rd_ok      (rd_ok),
        .blocked    (blocked),
        .wdata      (acc_wdata),
        .raw_vec    (raw_vec),
        .fast_vec   (fast_vec),
        .norm_vec   (norm_vec),
        .enable     (enable),
        .class_fast (class_fast),
        .soft_force (soft_force),
        .prot       (prot),
        .rdata      (acc_rdata),
        .err        (acc_err)
    );

    assign norm_status = norm_vec;

    // R5: the fast output rises only when some request line or force bit is active
    a_r5_fast_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        fast_irq |-> ((src_req | soft_force) != '0));
    // R6: no error pulse unless the previous cycle carried an access
    a_r6_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !acc_err);

endmodule

// File: tb/irq_mask_classify_tb.sv
module irq_mask_classify_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_priv = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err, fast_irq;
    logic [31:0] norm_status;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] m_en = '0, m_cls = '0, m_sw = '0;
    logic        m_prot = 1'b0;

    always #10 clk = ~clk;

    irq_mask_classify u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_priv(acc_priv),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err),
        .fast_irq(fast_irq), .norm_status(norm_status)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [5:0] a, input logic [31:0] d,
                       input logic pv, output logic [31:0] rd, output logic er);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d; acc_priv = pv;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
        rd = acc_rdata; er = acc_err;
    endtask

    // write and keep the bench model in step
    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic pv);
        logic [31:0] rd;
        logic er;
        if (!(m_prot && !pv)) begin
            case (a)
                6'h0C: m_cls = d;
                6'h10: m_en = m_en | d;
                6'h14: m_en = m_en & ~d;
                6'h18: m_sw = m_sw | d;
                6'h1C: m_sw = m_sw & ~d;
                6'h20: m_prot = d[0];
                default: ;
            endcase
        end
        acc(1'b1, a, d, pv, rd, er);
    endtask

    task automatic rdchk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] rd;
        logic er;
        acc(1'b0, a, 32'h0, 1'b1, rd, er);
        chk(req, rd, exp);
    endtask

    function automatic logic [31:0] lfsr(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic port_chk(input string req);
        logic [31:0] raw;
        raw = src_req | m_sw;
        chk(req, norm_status, raw & m_en & ~m_cls);
        chk(req, {31'b0, fast_irq}, {31'b0, |(raw & m_en & m_cls)});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, s;
        logic er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        chk("R8 norm_status", norm_status, 32'h0);
        chk("R8 fast_irq", {31'b0, fast_irq}, 32'h0);
        for (int a = 0; a <= 32; a += 4) rdchk("R8 register", 6'(a), 32'h0);
        chk("R8 idle rdata", acc_rdata, 32'h0);

        // R1: merged vector ignores enable and class
        src_req = 32'hA5A5_0003;
        rdchk("R1 raw from lines", 6'h08, 32'hA5A5_0003);
        wr(6'h18, 32'h0F00_0100, 1'b1);
        rdchk("R1 raw with force", 6'h08, 32'hAFA5_0103);
        chk("R1 nothing enabled", norm_status, 32'h0);

        // R3: force set and clear
        wr(6'h18, 32'h0000_0001, 1'b1);
        rdchk("R3 force set keeps", 6'h18, 32'h0F00_0101);
        wr(6'h1C, 32'h0F00_0000, 1'b1);
        rdchk("R3 force clear", 6'h18, 32'h0000_0101);
        rdchk("R7 force clear reads 0", 6'h1C, 32'h0);
        wr(6'h1C, 32'hFFFF_FFFF, 1'b1);
        rdchk("R3 force all clear", 6'h18, 32'h0);

        // R2: enable set and clear
        wr(6'h10, 32'hF0F0_00FF, 1'b1);
        wr(6'h10, 32'h0000_0F00, 1'b1);
        rdchk("R2 enable set ors", 6'h10, 32'hF0F0_0FFF);
        wr(6'h14, 32'h0000_00F0, 1'b1);
        rdchk("R2 enable clear", 6'h10, 32'hF0F0_0F0F);
        rdchk("R7 enable clear reads 0", 6'h14, 32'h0);

        // R4: class register
        wr(6'h0C, 32'h1234_5678, 1'b1);
        rdchk("R4 class readback", 6'h0C, 32'h1234_5678);
        wr(6'h0C, 32'h0000_0001, 1'b1);
        rdchk("R4 class overwrite", 6'h0C, 32'h0000_0001);

        // R5: one-hot sweep, every source in each class
        wr(6'h10, 32'hFFFF_FFFF, 1'b1);
        for (int i = 0; i < 32; i++) begin
            wr(6'h0C, 32'h1 << i, 1'b1);
            src_req = 32'h1 << i;
            @(negedge clk);
            chk("R5 one-hot fast", {31'b0, fast_irq}, 32'h1);
            chk("R5 one-hot fast no norm", norm_status, 32'h0);
            src_req = 32'h1 << ((i + 1) % 32);
            @(negedge clk);
            chk("R5 one-hot norm", norm_status, 32'h1 << ((i + 1) % 32));
            chk("R5 one-hot norm no fast", {31'b0, fast_irq}, 32'h0);
        end

        // R5: pseudo-random lines, masks and classes
        s = 32'h1ACE_B00C;
        for (int k = 0; k < 48; k++) begin
            wr(6'h14, 32'hFFFF_FFFF, 1'b1);
            s = lfsr(s); wr(6'h10, s, 1'b1);
            s = lfsr(s); wr(6'h0C, s ^ 32'h5A5A_5A5A, 1'b1);
            s = lfsr(s); src_req = s;
            if (k % 4 == 0) wr(6'h18, lfsr(s) & 32'h0000_FFFF, 1'b1);
            @(negedge clk);
            port_chk("R5 random ports");
            rdchk("R5 random normal status", 6'h00, (src_req | m_sw) & m_en & ~m_cls);
            rdchk("R5 random fast status", 6'h04, (src_req | m_sw) & m_en & m_cls);
            wr(6'h1C, 32'hFFFF_FFFF, 1'b1);
        end

        // R7: unmapped and read-only offsets
        wr(6'h0C, 32'h0, 1'b1);
        src_req = 32'h0000_00F0;
        wr(6'h24, 32'hFFFF_FFFF, 1'b1);
        wr(6'h00, 32'hFFFF_FFFF, 1'b1);
        wr(6'h08, 32'hFFFF_FFFF, 1'b1);
        rdchk("R7 unmapped read", 6'h24, 32'h0);
        rdchk("R7 raw unchanged by write", 6'h08, 32'h0000_00F0);
        rdchk("R7 enable unchanged by ro writes", 6'h10, m_en);
        rdchk("R7 class unchanged by ro writes", 6'h0C, 32'h0);

        // R6: protection off -> user access works without error
        acc(1'b1, 6'h10, 32'h8000_0000, 1'b0, rd, er);
        m_en = m_en | 32'h8000_0000;
        chk("R6 user write no err", {31'b0, er}, 32'h0);
        acc(1'b0, 6'h10, 32'h0, 1'b0, rd, er);
        chk("R6 user read open", rd, m_en);
        // protection on
        wr(6'h20, 32'h1, 1'b1);
        rdchk("R6 prot readback", 6'h20, 32'h1);
        acc(1'b0, 6'h10, 32'h0, 1'b0, rd, er);
        chk("R6 blocked read zero", rd, 32'h0);
        chk("R6 blocked read err", {31'b0, er}, 32'h1);
        @(negedge clk);
        chk("R6 err lasts one cycle", {31'b0, acc_err}, 32'h0);
        wr(6'h14, 32'hFFFF_FFFF, 1'b0);
        wr(6'h20, 32'h0, 1'b0);
        wr(6'h18, 32'hFFFF_FFFF, 1'b0);
        rdchk("R6 blocked enable clear", 6'h10, m_en);
        rdchk("R6 blocked prot clear", 6'h20, 32'h1);
        rdchk("R6 blocked force set", 6'h18, 32'h0);
        acc(1'b0, 6'h08, 32'h0, 1'b1, rd, er);
        chk("R6 priv no err", {31'b0, er}, 32'h0);
        wr(6'h20, 32'h0, 1'b1);
        acc(1'b0, 6'h20, 32'h0, 1'b0, rd, er);
        chk("R6 user open again", {rd[31:1], er}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule